// File: doc/BRIEF.md
# Flash configuration register bank with two-step software reset

This block holds the configuration state of a serial flash device model: a 16-bit non-volatile configuration word, an 8-bit volatile configuration register, an 8-bit enhanced volatile configuration register, a write-enable latch, a 4-byte addressing flag and a small extended address (segment) register. A command front end presents one opcode per command on `cmd_valid`/`cmd_op` and then streams the command's data bytes on `din_valid`/`din`. For read commands it pulls response bytes from `dout` with `dout_next`. All register contents also leave the block as plain outputs, so the address path and the read path can use them directly.

A software reset takes two opcodes: an arming opcode, and then a firing opcode that takes effect only if the opcode just before it was the arming one. The reset does not load fixed constants. It rebuilds the volatile registers, the 4-byte flag and the segment register from fields of the current non-volatile word. The hardware reset applies the same rebuild to the parameter `NV_DEFAULT`. The non-volatile word keeps its value through the software reset.

Top module: `cfg_flash_regs`

## Requirements
- R1: After hardware reset, with the default `NV_DEFAULT` of 0x8FFF: `nv_cfg`=0x8FFF, `v_cfg`=0x83, `ev_cfg`=0xDF, `addr4_mode`=0, `ext_addr`=0, `wr_en`=0 and `dout_valid`=0.
- R2: Opcode 0x06 sets `wr_en` and opcode 0x04 clears it. No other opcode sets it. The register writes below leave it unchanged.
- R3: With `wr_en` set, opcode 0xB1 followed by two data bytes loads `nv_cfg`, low byte first. Opcode 0xB5 returns `nv_cfg` on `dout` as two bytes, low byte first, each one presented while `dout_valid` is high and stepped with `dout_next`.
- R4: With `wr_en` set, opcode 0x81 with one data byte loads `v_cfg`, and opcode 0x61 with one data byte loads `ev_cfg`. Opcodes 0x85 and 0x65 return these registers as one byte each.
- R5: Write opcodes 0xB1, 0x81, 0x61 and 0xC5 issued while `wr_en` is clear are ignored, and so are the data bytes that follow them.
- R6: Opcode 0xB7 sets `addr4_mode` and 0xE9 clears it. With `wr_en` set, 0xC5 with one data byte loads `ext_addr` from that byte's low `SEG_W` bits. Opcode 0xC8 returns `ext_addr` zero-extended to one byte.
- R7: Opcode 0x66 arms the reset. Opcode 0x99 performs the reset only when the opcode before it was 0x66. Any other opcode disarms, so an unarmed 0x99 changes nothing.
- R8: A performed reset clears `wr_en` and sets `v_cfg` to: bits 1:0 = 11, bit 2 = 0, bit 3 = 1 unless `nv_cfg[11:9]` is 111, bits 7:4 = `nv_cfg[15:12]`.
- R9: A performed reset sets `ev_cfg` to: bits 2:0 = 111, bits 4:3 = 11, bit 5 = 0, bit 6 = `nv_cfg[2]`, bit 7 = `nv_cfg[3]`.
- R10: A performed reset sets `addr4_mode` to the inverse of `nv_cfg[0]`. It sets `ext_addr` to all ones when `nv_cfg[1]` is 0 and to zero otherwise. `nv_cfg` itself is unchanged.
- R11: A new opcode ends any unfinished data collection or read. `dout_valid` drops after the last byte of a read has been stepped past, and data bytes arriving outside a write collection are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| cmd_valid | input | 1 | A new command opcode is present this cycle |
| cmd_op | input | 8 | Command opcode |
| din_valid | input | 1 | A command data byte is present this cycle |
| din | input | 8 | Command data byte |
| dout_next | input | 1 | Step to the next response byte |
| dout | output | 8 | Current response byte |
| dout_valid | output | 1 | `dout` holds a response byte |
| wr_en | output | 1 | Write-enable latch |
| addr4_mode | output | 1 | 4-byte addressing active |
| ext_addr | output | SEG_W | Extended address segment |
| nv_cfg | output | 16 | Non-volatile configuration word |
| v_cfg | output | 8 | Volatile configuration register |
| ev_cfg | output | 8 | Enhanced volatile configuration register |

## Verification
The bench loads non-volatile words whose bits 11:9 are all ones or not, and whose bits 0 to 3 are set or clear, and then fires a reset. A rebuild that inverted the bit 3 test, swapped the two enhanced bits, or left the 4-byte flag or segment at a constant would show up as wrong register values. It puts a different opcode between the arming and firing opcodes, so a design that remembered the arm state would reset when it should not. It also checks byte order on the 16-bit write and read, writes issued without write enable, and a collection cut off by a new opcode, where a wrong design would swap bytes or commit a half-written word.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   localparam logic [7:0] OP_WEL_SET  = 8'h06;
   localparam logic [7:0] OP_WEL_CLR  = 8'h04;
   localparam logic [7:0] OP_NV_WR    = 8'hB1;
   localparam logic [7:0] OP_NV_RD    = 8'hB5;
   localparam logic [7:0] OP_VC_WR    = 8'h81;
   localparam logic [7:0] OP_VC_RD    = 8'h85;
   localparam logic [7:0] OP_EV_WR    = 8'h61;
   localparam logic [7:0] OP_EV_RD    = 8'h65;
   localparam logic [7:0] OP_A4_ON    = 8'hB7;
   localparam logic [7:0] OP_A4_OFF   = 8'hE9;
   localparam logic [7:0] OP_SEG_WR   = 8'hC5;
   localparam logic [7:0] OP_SEG_RD   = 8'hC8;
   localparam logic [7:0] OP_RST_ARM  = 8'h66;
   localparam logic [7:0] OP_RST_FIRE = 8'h99;

   localparam int NV_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_NV   = 3'd1,
      TGT_VC   = 3'd2,
      TGT_EV   = 3'd3,
      TGT_SEG  = 3'd4
   } tgt_e;

   typedef struct packed {
      logic wel_set;
      logic wel_clr;
      logic a4_on;
      logic a4_off;
      logic arm;
      logic fire;
      logic is_wr;
      logic is_rd;
      tgt_e tgt;
   } dec_t;

   // Volatile register image rebuilt from the non-volatile word.
   function automatic logic [7:0] derive_vc(input logic [NV_W-1:0] nv);
      logic [7:0] v;
      v = '0;
      v[0] = 1'b1;
      v[1] = 1'b1;
      v[3] = (nv[11:9] != 3'b111);
      v[7:4] = nv[15:12];
      return v;
   endfunction

   // Enhanced volatile register image rebuilt from the non-volatile word.
   function automatic logic [7:0] derive_ev(input logic [NV_W-1:0] nv);
      logic [7:0] e;
      e = '0;
      e[2:0] = 3'b111;
      e[3] = 1'b1;
      e[4] = 1'b1;
      e[6] = nv[2];
      e[7] = nv[3];
      return e;
   endfunction

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
   import cfgreg_pkg::*;
(
   input  logic [7:0] op,
   output dec_t       dec
);

   always_comb begin
      dec = '0;
      dec.tgt = TGT_NONE;
      case (op)
         OP_WEL_SET:  dec.wel_set = 1'b1;
         OP_WEL_CLR:  dec.wel_clr = 1'b1;
         OP_A4_ON:    dec.a4_on = 1'b1;
         OP_A4_OFF:   dec.a4_off = 1'b1;
         OP_RST_ARM:  dec.arm = 1'b1;
         OP_RST_FIRE: dec.fire = 1'b1;
         OP_NV_WR:    begin dec.is_wr = 1'b1; dec.tgt = TGT_NV;  end
         OP_VC_WR:    begin dec.is_wr = 1'b1; dec.tgt = TGT_VC;  end
         OP_EV_WR:    begin dec.is_wr = 1'b1; dec.tgt = TGT_EV;  end
         OP_SEG_WR:   begin dec.is_wr = 1'b1; dec.tgt = TGT_SEG; end
         OP_NV_RD:    begin dec.is_rd = 1'b1; dec.tgt = TGT_NV;  end
         OP_VC_RD:    begin dec.is_rd = 1'b1; dec.tgt = TGT_VC;  end
         OP_EV_RD:    begin dec.is_rd = 1'b1; dec.tgt = TGT_EV;  end
         OP_SEG_RD:   begin dec.is_rd = 1'b1; dec.tgt = TGT_SEG; end
         default:     dec = '0;
      endcase
   end

endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic is_arm,
   input  logic is_fire,
   output logic fire
);

   logic armed_q;

   // Every opcode rewrites the arm flag, so only an adjacent pair fires.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (cmd_valid)
         armed_q <= is_arm;
   end

   assign fire = cmd_valid && is_fire && armed_q;

endmodule

// File: rtl/cfg_xfer.sv
module cfg_xfer
   import cfgreg_pkg::*;
#(
   parameter int SEG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              is_wr,
   input  logic              is_rd,
   input  tgt_e              tgt,
   input  logic              wel,
   input  logic              din_valid,
   input  logic [7:0]        din,
   input  logic              dout_next,
   input  logic [NV_W-1:0]   nv,
   input  logic [7:0]        vc,
   input  logic [7:0]        ev,
   input  logic [SEG_W-1:0]  seg,
   output logic              wr_stb,
   output tgt_e              wr_tgt,
   output logic [NV_W-1:0]   wr_word,
   output logic [7:0]        dout,
   output logic              dout_valid
);

   logic       col_q;
   logic       rd_q;
   tgt_e       tgt_q;
   logic       idx_q;
   logic [7:0] lo_q;
   logic       last;
   logic [7:0] seg_byte;

   generate
      if (SEG_W < BYTE_W) begin : g_seg_pad
         assign seg_byte = {{(BYTE_W-SEG_W){1'b0}}, seg};
      end else begin : g_seg_full
         assign seg_byte = seg[BYTE_W-1:0];
      end
   endgenerate

   // Only the non-volatile word spans two bytes.
   assign last = (tgt_q == TGT_NV) ? idx_q : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= 1'b0;
         rd_q  <= 1'b0;
         tgt_q <= TGT_NONE;
         idx_q <= 1'b0;
         lo_q  <= '0;
      end else if (cmd_valid) begin
         col_q <= is_wr && wel;
         rd_q  <= is_rd;
         tgt_q <= tgt;
         idx_q <= 1'b0;
      end else if (col_q && din_valid) begin
         if (last)
            col_q <= 1'b0;
         else begin
            idx_q <= 1'b1;
            lo_q  <= din;
         end
      end else if (rd_q && dout_next) begin
         if (last)
            rd_q <= 1'b0;
         else
            idx_q <= 1'b1;
      end
   end

   assign wr_stb  = !cmd_valid && col_q && din_valid && last;
   assign wr_tgt  = tgt_q;
   assign wr_word = (tgt_q == TGT_NV) ? {din, lo_q} : {8'h00, din};

   always_comb begin
      case (tgt_q)
         TGT_NV:  dout = idx_q ? nv[15:8] : nv[7:0];
         TGT_VC:  dout = vc;
         TGT_EV:  dout = ev;
         TGT_SEG: dout = seg_byte;
         default: dout = 8'h00;
      endcase
   end

   assign dout_valid = rd_q;

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
   import cfgreg_pkg::*;
#(
   parameter logic [15:0] NV_DEFAULT = 16'h8FFF,
   parameter int          SEG_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              a4_on,
   input  logic              a4_off,
   input  logic              fire,
   input  logic              wr_stb,
   input  tgt_e              wr_tgt,
   input  logic [NV_W-1:0]   wr_word,
   output logic              wel,
   output logic              a4,
   output logic [SEG_W-1:0]  seg,
   output logic [NV_W-1:0]   nv,
   output logic [7:0]        vc,
   output logic [7:0]        ev
);

   localparam logic [SEG_W-1:0] SEG_ALL = {SEG_W{1'b1}};
   localparam logic [SEG_W-1:0] SEG_RST = NV_DEFAULT[1] ? '0 : SEG_ALL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv  <= NV_DEFAULT;
         vc  <= derive_vc(NV_DEFAULT);
         ev  <= derive_ev(NV_DEFAULT);
         a4  <= !NV_DEFAULT[0];
         seg <= SEG_RST;
         wel <= 1'b0;
      end else if (fire) begin
         wel <= 1'b0;
         vc  <= derive_vc(nv);
         ev  <= derive_ev(nv);
         a4  <= !nv[0];
         seg <= nv[1] ? '0 : SEG_ALL;
      end else begin
         if (cmd_valid && wel_set) wel <= 1'b1;
         if (cmd_valid && wel_clr) wel <= 1'b0;
         if (cmd_valid && a4_on)   a4  <= 1'b1;
         if (cmd_valid && a4_off)  a4  <= 1'b0;
         if (wr_stb) begin
            case (wr_tgt)
               TGT_NV:  nv  <= wr_word;
               TGT_VC:  vc  <= wr_word[7:0];
               TGT_EV:  ev  <= wr_word[7:0];
               TGT_SEG: seg <= wr_word[SEG_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_flash_regs.sv
module cfg_flash_regs
   import cfgreg_pkg::*;
#(
   parameter logic [15:0] NV_DEFAULT = 16'h8FFF,
   parameter int          SEG_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic              din_valid,
   input  logic [7:0]        din,
   input  logic              dout_next,
   output logic [7:0]        dout,
   output logic              dout_valid,
   output logic              wr_en,
   output logic              addr4_mode,
   output logic [SEG_W-1:0]  ext_addr,
   output logic [15:0]       nv_cfg,
   output logic [7:0]        v_cfg,
   output logic [7:0]        ev_cfg
);

   generate
      if (SEG_W < 1 || SEG_W > BYTE_W) begin : g_bad_seg
         $error("cfg_flash_regs: SEG_W must lie in 1..8");
      end
   endgenerate

   dec_t            dec;
   logic            fire;
   logic            wr_stb;
   tgt_e            wr_tgt;
   logic [NV_W-1:0] wr_word;

   cfg_cmd_decode u_dec (
      .op  (cmd_op),
      .dec (dec)
   );

   cfg_reset_seq u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .is_arm    (dec.arm),
      .is_fire   (dec.fire),
      .fire      (fire)
   );

   cfg_xfer #(.SEG_W(SEG_W)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .is_wr      (dec.is_wr),
      .is_rd      (dec.is_rd),
      .tgt        (dec.tgt),
      .wel        (wr_en),
      .din_valid  (din_valid),
      .din        (din),
      .dout_next  (dout_next),
      .nv         (nv_cfg),
      .vc         (v_cfg),
      .ev         (ev_cfg),
      .seg        (ext_addr),
      .wr_stb     (wr_stb),
      .wr_tgt     (wr_tgt),
      .wr_word    (wr_word),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

   cfg_reg_file #(.NV_DEFAULT(NV_DEFAULT), .SEG_W(SEG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .wel_set   (dec.wel_set),
      .wel_clr   (dec.wel_clr),
      .a4_on     (dec.a4_on),
      .a4_off    (dec.a4_off),
      .fire      (fire),
      .wr_stb    (wr_stb),
      .wr_tgt    (wr_tgt),
      .wr_word   (wr_word),
      .wel       (wr_en),
      .a4        (addr4_mode),
      .seg       (ext_addr),
      .nv        (nv_cfg),
      .vc        (v_cfg),
      .ev        (ev_cfg)
   );

endmodule

// File: rtl/cfg_flash_regs_chk.sv
module cfg_flash_regs_chk #(
   parameter int SEG_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [7:0]       cmd_op,
   input logic             dout_valid,
   input logic             wr_en,
   input logic             addr4_mode,
   input logic [SEG_W-1:0] ext_addr,
   input logic [15:0]      nv_cfg,
   input logic [7:0]       v_cfg,
   input logic [7:0]       ev_cfg
);

   // Independent record of the previous opcode, for the arm/fire pairing.
   logic [7:0] prev_op;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_op <= 8'h00;
      else if (cmd_valid)
         prev_op <= cmd_op;
   end

   logic fire_armed, fire_unarmed, rd_op;
   assign fire_armed   = cmd_valid && cmd_op == 8'h99 && prev_op == 8'h66;
   assign fire_unarmed = cmd_valid && cmd_op == 8'h99 && prev_op != 8'h66;
   assign rd_op = cmd_op == 8'hB5 || cmd_op == 8'h85 || cmd_op == 8'h65 || cmd_op == 8'hC8;

   a_r2_wel_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> $past(cmd_valid && cmd_op == 8'h06));

   a_r5_nv_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(nv_cfg));

   a_r5_vc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !fire_armed) |=> $stable(v_cfg));

   a_r7_unarmed_noop: assert property (@(posedge clk) disable iff (!rst_n)
      fire_unarmed |=> ($stable(ev_cfg) && $stable(addr4_mode) && $stable(ext_addr)));

   a_r8_vc_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      fire_armed |=> (!wr_en && v_cfg[1:0] == 2'b11 && !v_cfg[2] && v_cfg[7:4] == nv_cfg[15:12]));

   a_r9_ev_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      fire_armed |=> (ev_cfg[4:0] == 5'h1F && !ev_cfg[5] && ev_cfg[6] == nv_cfg[2] && ev_cfg[7] == nv_cfg[3]));

   a_r10_a4_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      fire_armed |=> (addr4_mode == !nv_cfg[0]));

   a_r11_read_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !rd_op) |=> !dout_valid);

endmodule

bind cfg_flash_regs cfg_flash_regs_chk #(.SEG_W(SEG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .dout_valid (dout_valid),
   .wr_en      (wr_en),
   .addr4_mode (addr4_mode),
   .ext_addr   (ext_addr),
   .nv_cfg     (nv_cfg),
   .v_cfg      (v_cfg),
   .ev_cfg     (ev_cfg)
);

// File: tb/sim_cfg_flash_regs.sv
module sim_cfg_flash_regs;

   localparam int CLK_P = 10;
   localparam int SEG_W = 2;
   localparam int WD_CYCLES = 100000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [7:0]       cmd_op = 8'h00;
   logic             din_valid = 1'b0;
   logic [7:0]       din = 8'h00;
   logic             dout_next = 1'b0;
   logic [7:0]       dout;
   logic             dout_valid;
   logic             wr_en;
   logic             addr4_mode;
   logic [SEG_W-1:0] ext_addr;
   logic [15:0]      nv_cfg;
   logic [7:0]       v_cfg;
   logic [7:0]       ev_cfg;

   int n_chk = 0;
   int n_fail = 0;

   // Model state built from the requirements.
   logic [15:0]      m_nv;
   logic [7:0]       m_vc, m_ev;
   logic             m_we, m_a4, m_arm;
   logic [SEG_W-1:0] m_seg;

   always #(CLK_P/2) clk = ~clk;

   cfg_flash_regs #(.NV_DEFAULT(16'h8FFF), .SEG_W(SEG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .din_valid(din_valid), .din(din), .dout_next(dout_next),
      .dout(dout), .dout_valid(dout_valid), .wr_en(wr_en),
      .addr4_mode(addr4_mode), .ext_addr(ext_addr), .nv_cfg(nv_cfg),
      .v_cfg(v_cfg), .ev_cfg(ev_cfg)
   );

   function automatic logic [7:0] exp_vc(input logic [15:0] nv);
      return {nv[15:12], (nv[11:9] != 3'b111), 3'b011};
   endfunction

   function automatic logic [7:0] exp_ev(input logic [15:0] nv);
      return {nv[3], nv[2], 6'b011111};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      #1;
      chk(nv_cfg == m_nv, {tag, " nv"}, nv_cfg, m_nv);
      chk(v_cfg == m_vc, {tag, " vc"}, v_cfg, m_vc);
      chk(ev_cfg == m_ev, {tag, " ev"}, ev_cfg, m_ev);
      chk(wr_en == m_we, {tag, " we"}, wr_en, m_we);
      chk(addr4_mode == m_a4, {tag, " a4"}, addr4_mode, m_a4);
      chk(ext_addr == m_seg, {tag, " seg"}, ext_addr, m_seg);
   endtask

   task automatic model_op(input logic [7:0] op);
      if (op == 8'h99 && m_arm) begin
         m_we = 1'b0;
         m_vc = exp_vc(m_nv);
         m_ev = exp_ev(m_nv);
         m_a4 = !m_nv[0];
         m_seg = m_nv[1] ? '0 : '1;
      end
      if (op == 8'h06) m_we = 1'b1;
      if (op == 8'h04) m_we = 1'b0;
      if (op == 8'hB7) m_a4 = 1'b1;
      if (op == 8'hE9) m_a4 = 1'b0;
      m_arm = (op == 8'h66);
   endtask

   task automatic send_op(input logic [7:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = op;
      @(negedge clk);
      cmd_valid = 1'b0;
      model_op(op);
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      din_valid = 1'b1;
      din = b;
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi);
      send_op(op);
      send_byte(lo);
      if (op == 8'hB1) send_byte(hi);
      if (m_we) begin
         case (op)
            8'hB1: m_nv = {hi, lo};
            8'h81: m_vc = lo;
            8'h61: m_ev = lo;
            8'hC5: m_seg = lo[SEG_W-1:0];
            default: ;
         endcase
      end
   endtask

   // Reads n bytes, checking each against the model, then checks the read has ended.
   task automatic do_read(input logic [7:0] op, input string tag);
      logic [7:0] exp [2];
      int n;
      n = 1;
      case (op)
         8'hB5: begin exp[0] = m_nv[7:0]; exp[1] = m_nv[15:8]; n = 2; end
         8'h85: exp[0] = m_vc;
         8'h65: exp[0] = m_ev;
         default: exp[0] = 8'(m_seg);
      endcase
      send_op(op);
      for (int i = 0; i < n; i++) begin
         #1;
         chk(dout_valid && dout == exp[i], tag, {dout_valid, dout}, {1'b1, exp[i]});
         dout_next = 1'b1;
         @(negedge clk);
         dout_next = 1'b0;
      end
      #1;
      chk(!dout_valid, {tag, " end R11"}, dout_valid, 0);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      m_nv = 16'h8FFF; m_vc = 8'h83; m_ev = 8'hDF;
      m_we = 0; m_a4 = 0; m_seg = '0; m_arm = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_regs("R1 reset");
      chk(!dout_valid, "R1 dout_valid", dout_valid, 0);

      // R5: writes without write enable are ignored
      do_write(8'hB1, 8'h12, 8'h34); chk_regs("R5 nv no wel");
      do_write(8'h81, 8'h55, 8'h00); chk_regs("R5 vc no wel");
      do_write(8'hC5, 8'h03, 8'h00); chk_regs("R5 seg no wel");
      // R2
      send_op(8'h06); chk_regs("R2 wel set");
      send_op(8'h04); chk_regs("R2 wel clr");
      send_op(8'h06);
      // R3 byte order
      do_write(8'hB1, 8'hA5, 8'h3C); chk_regs("R3 nv write");
      do_read(8'hB5, "R3 nv read");
      // R4
      do_write(8'h81, 8'h5A, 8'h00); chk_regs("R4 vc write");
      do_read(8'h85, "R4 vc read");
      do_write(8'h61, 8'hC3, 8'h00); chk_regs("R4 ev write");
      do_read(8'h65, "R4 ev read");
      // R6
      send_op(8'hB7); chk_regs("R6 a4 on");
      send_op(8'hE9); chk_regs("R6 a4 off");
      do_write(8'hC5, 8'hFE, 8'h00); chk_regs("R6 seg write");
      do_read(8'hC8, "R6 seg read");
      // R11: collection cut off by a new opcode, stray byte ignored
      send_op(8'h06);
      send_op(8'hB1);
      send_byte(8'h77);
      do_read(8'h85, "R11 abort read");
      send_byte(8'h99);
      chk_regs("R11 abort");
      // R8-R10 with all-zero non-volatile word
      do_write(8'hB1, 8'h00, 8'h00);
      send_op(8'h66); send_op(8'h99);
      chk_regs("R8 R9 R10 nv=0000");
      chk(v_cfg == 8'h0B && ev_cfg == 8'h1F && addr4_mode && ext_addr == 2'b11,
          "R10 fixed values", {v_cfg, ev_cfg}, 16'h0B1F);
      // R7: unarmed fire
      send_op(8'hB7); send_op(8'h06);
      do_write(8'h81, 8'h00, 8'h00);
      send_op(8'h66); send_op(8'h06); send_op(8'h99);
      chk_regs("R7 unarmed");
      // nv with bits 11:9 all ones and bits 3..0 mixed
      do_write(8'hB1, 8'h0A, 8'h6E);
      send_op(8'h66); send_op(8'h99);
      chk_regs("R8 R9 R10 nv=6E0A");

      for (int it = 0; it < 400; it++) begin
         int r;
         r = $urandom % 12;
         case (r)
            0: send_op(8'h06);
            1: send_op(8'h04);
            2: begin send_op(8'h66); if ($urandom % 4 == 0) send_op(8'h06); send_op(8'h99); end
            3: do_write(8'hB1, 8'($urandom), 8'($urandom));
            4: do_write(8'h81, 8'($urandom), 8'h00);
            5: do_write(8'h61, 8'($urandom), 8'h00);
            6: do_write(8'hC5, 8'($urandom), 8'h00);
            7: send_op($urandom % 2 ? 8'hB7 : 8'hE9);
            8: do_read(8'hB5, "R3 rand read");
            9: do_read($urandom % 2 ? 8'h85 : 8'h65, "R4 rand read");
            10: do_read(8'hC8, "R6 rand read");
            default: send_op(8'h99);
         endcase
         chk_regs("R8 R9 R10 rand");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule